// File: doc/BRIEF.md
# Dual-Port Interleaved Bank Arbiter

This block lets two memory request ports, each carrying a load or a store, share eight single-ported storage banks in the same clock cycle. A field of the word address picks the bank. The remaining address bits pick the word inside that bank. A crossbar steers each granted request to its bank. When both ports name the same bank in one cycle, one port is granted and the other is told to replay, in the same way a cache miss would be reported. The scheduler that reissues the losing request is outside this block.

The position of the bank-select field is a parameter. A low position spreads consecutive words across the banks. A higher position gives each bank a contiguous region. Priority on a conflict is fixed to port 0 by default. When the `prio_rotate` input is high, the winner alternates from one conflict to the next so that neither port is starved. Load data comes back on the issuing port one cycle after the grant.

Top module: `bank_arb_top`

## Requirements
- R1: The bank of a request is `addr[BANK_LSB +: 3]`, with BANK_LSB = 2 by default. The word inside the bank is the address with that field removed: bits above the field move down and bits below it stay in place. Every address therefore maps to one distinct word.
- R2: When both ports request different banks in a cycle, both are granted in that cycle and neither sees replay. This holds for any mix of loads and stores.
- R3: When both ports request the same bank in a cycle, exactly one is granted and the other sees replay in that same cycle. This also applies when both are loads of the identical word.
- R4: With `prio_rotate` low, port 0 wins every conflict.
- R5: With `prio_rotate` high, the winner alternates on each conflict. Port 0 wins first after reset and after any cycle with `prio_rotate` low. Cycles without a conflict do not change whose turn it is.
- R6: A granted load raises `rvalid` on its own port in the next cycle, with the addressed word on `rdata`. A store, a replayed request or no request leaves `rvalid` low in the next cycle.
- R7: A granted store writes its word at the clock edge. A replayed store leaves memory unchanged.
- R8: A port with `req` low gets neither grant nor replay.
- R9: After reset, `rvalid` is low on both ports and conflict priority starts at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_rotate | input | 1 | Alternate conflict priority when high |
| p0_req | input | 1 | Port 0 request valid |
| p0_we | input | 1 | Port 0 store (1) or load (0) |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 store data |
| p0_grant | output | 1 | Port 0 request accepted this cycle |
| p0_replay | output | 1 | Port 0 lost a bank conflict |
| p0_rvalid | output | 1 | Port 0 load data valid |
| p0_rdata | output | DATA_W | Port 0 load data |
| p1_req | input | 1 | Port 1 request valid |
| p1_we | input | 1 | Port 1 store (1) or load (0) |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 store data |
| p1_grant | output | 1 | Port 1 request accepted this cycle |
| p1_replay | output | 1 | Port 1 lost a bank conflict |
| p1_rvalid | output | 1 | Port 1 load data valid |
| p1_rdata | output | DATA_W | Port 1 load data |

## Verification
The properties assume that `we` and `addr` are stable and known whenever `req` is high. They also assume `prio_rotate` only changes between cycles, because the rotation check tracks its own expected turn from that input. The stimulus drives every input on the falling edge and holds it for the whole cycle. Every word is written before it is read, so the read-data comparisons never meet uninitialised storage.

// File: rtl/bank_arb_pkg.sv
// Shared types for the dual-port bank arbiter.
// Assumes exactly two request ports.
package bank_arb_pkg;

    // Identifies which port holds priority on the next conflict.
    typedef enum logic {
        PORT0 = 1'b0,
        PORT1 = 1'b1
    } port_e;

endpackage

// File: rtl/bank_arb_arbiter.sv
// Conflict detector and priority keeper.
// Compares the two bank indices in the cycle they arrive. On a match it
// grants one port and marks the other for replay. Priority is fixed to
// port 0, or alternates per conflict while prio_rotate is high.
// Assumes req, bank and prio_rotate are stable during the cycle.
module bank_arb_arbiter
    import bank_arb_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_rotate,
    input  logic              req0,
    input  logic              req1,
    input  logic [BANK_W-1:0] bank0,
    input  logic [BANK_W-1:0] bank1,
    output logic              grant0,
    output logic              grant1,
    output logic              replay0,
    output logic              replay1
);

    port_e turn;
    logic  clash;
    logic  p1_wins;

    // Same-bank detection and outcome for this cycle.
    always_comb begin
        clash   = req0 && req1 && (bank0 == bank1);
        p1_wins = prio_rotate && (turn == PORT1);
        grant0  = req0 && !(clash && p1_wins);
        grant1  = req1 && !(clash && !p1_wins);
        replay0 = clash && p1_wins;
        replay1 = clash && !p1_wins;
    end

    // Priority turn: cleared while rotation is off, flipped on each clash.
    always_ff @(posedge clk) begin
        if (!rst_n || !prio_rotate) begin
            turn <= PORT0;
        end else if (clash) begin
            turn <= (turn == PORT0) ? PORT1 : PORT0;
        end
    end

endmodule

// File: rtl/bank_arb_sram.sv
// Single-port storage bank model with one registered read.
// Assumes at most one access per cycle. Contents are not reset.
module bank_arb_sram #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 5
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // One access per cycle: write the word or latch it for reading.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wdata;
        end else if (en) begin
            rdata <= mem[row];
        end
    end

endmodule

// File: rtl/bank_arb_top.sv
// Two request ports sharing NUM_BANKS single-port banks through a crossbar.
// The bank index is taken from address bits starting at BANK_LSB. The
// remaining bits form the row. Granted requests are steered to their
// banks. Load data returns on the issuing port one cycle after the grant.
// Assumes NUM_BANKS is a power of two and BANK_LSB + log2(NUM_BANKS) <= ADDR_W.
module bank_arb_top #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 8,
    parameter int BANK_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_rotate,
    input  logic              p0_req,
    input  logic              p0_we,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic              p0_grant,
    output logic              p0_replay,
    output logic              p0_rvalid,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_req,
    input  logic              p1_we,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_grant,
    output logic              p1_replay,
    output logic              p1_rvalid,
    output logic [DATA_W-1:0] p1_rdata
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam logic [ADDR_W-1:0] LO_MASK = ADDR_W'((1 << BANK_LSB) - 1);

    // Removes the bank field from an address, packing the row bits.
    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] hi;
        hi = a >> (BANK_LSB + BANK_W);
        return ROW_W'((hi << BANK_LSB) | (a & LO_MASK));
    endfunction

    logic [BANK_W-1:0] p0_bank, p1_bank;
    logic [ROW_W-1:0]  p0_row, p1_row;
    logic [BANK_W-1:0] p0_rd_bank, p1_rd_bank;
    logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

    // Address split into bank index and row.
    always_comb begin
        p0_bank = p0_addr[BANK_LSB +: BANK_W];
        p1_bank = p1_addr[BANK_LSB +: BANK_W];
        p0_row  = row_of(p0_addr);
        p1_row  = row_of(p1_addr);
    end

    bank_arb_arbiter #(.BANK_W(BANK_W)) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_rotate (prio_rotate),
        .req0        (p0_req),
        .req1        (p1_req),
        .bank0       (p0_bank),
        .bank1       (p1_bank),
        .grant0      (p0_grant),
        .grant1      (p1_grant),
        .replay0     (p0_replay),
        .replay1     (p1_replay)
    );

    // Crossbar: each bank takes the granted port that addresses it.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit0, hit1;
        assign hit0 = p0_grant && (p0_bank == BANK_W'(b));
        assign hit1 = p1_grant && (p1_bank == BANK_W'(b));

        bank_arb_sram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) sram_i (
            .clk   (clk),
            .en    (hit0 || hit1),
            .we    (hit1 ? p1_we    : p0_we),
            .row   (hit1 ? p1_row   : p0_row),
            .wdata (hit1 ? p1_wdata : p0_wdata),
            .rdata (bank_rdata[b])
        );
    end

    // Return path: remember which bank each granted load used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_rvalid  <= 1'b0;
            p1_rvalid  <= 1'b0;
            p0_rd_bank <= '0;
            p1_rd_bank <= '0;
        end else begin
            p0_rvalid  <= p0_grant && !p0_we;
            p1_rvalid  <= p1_grant && !p1_we;
            p0_rd_bank <= p0_bank;
            p1_rd_bank <= p1_bank;
        end
    end

    // Load data routed back from the recorded bank.
    always_comb begin
        p0_rdata = bank_rdata[p0_rd_bank];
        p1_rdata = bank_rdata[p1_rd_bank];
    end

endmodule

// File: rtl/bank_arb_checker.sv
// Protocol properties for bank_arb_top, attached with bind.
// Assumes request inputs are held steady through each cycle.
module bank_arb_checker #(
    parameter int ADDR_W   = 8,
    parameter int BANK_LSB = 2,
    parameter int BANK_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prio_rotate,
    input logic              p0_req,
    input logic              p0_we,
    input logic [ADDR_W-1:0] p0_addr,
    input logic              p0_grant,
    input logic              p0_replay,
    input logic              p0_rvalid,
    input logic              p1_req,
    input logic              p1_we,
    input logic [ADDR_W-1:0] p1_addr,
    input logic              p1_grant,
    input logic              p1_replay,
    input logic              p1_rvalid
);

    logic same_bank;
    logic both_req;
    logic want_p1;

    assign both_req  = p0_req && p1_req;
    assign same_bank = p0_addr[BANK_LSB +: BANK_W] == p1_addr[BANK_LSB +: BANK_W];

    // Expected rotating winner, tracked from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n || !prio_rotate) begin
            want_p1 <= 1'b0;
        end else if (both_req && same_bank) begin
            want_p1 <= !want_p1;
        end
    end

    AST_DIFF_BANK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (both_req && !same_bank) |-> (p0_grant && p1_grant && !p0_replay && !p1_replay)); // R2
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (both_req && same_bank) |-> ($countones({p0_grant, p1_grant}) == 1
            && p0_replay == p1_grant && p1_replay == p0_grant)); // R3
    AST_FIXED_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_rotate && both_req && same_bank) |-> p0_grant); // R4
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_rotate && both_req && same_bank) |-> (p1_grant == want_p1)); // R5
    AST_LOAD_RETURN0: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_grant && !p0_we) |=> p0_rvalid); // R6
    AST_LOAD_RETURN1: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_grant && !p1_we) |=> p1_rvalid); // R6
    AST_NO_SPURIOUS0: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_grant && !p0_we) |=> !p0_rvalid); // R6
    AST_NO_SPURIOUS1: assert property (@(posedge clk) disable iff (!rst_n)
        !(p1_grant && !p1_we) |=> !p1_rvalid); // R6
    AST_IDLE0: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_req |-> (!p0_grant && !p0_replay)); // R8
    AST_IDLE1: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_req |-> (!p1_grant && !p1_replay)); // R8

endmodule

bind bank_arb_top bank_arb_checker #(
    .ADDR_W   (ADDR_W),
    .BANK_LSB (BANK_LSB),
    .BANK_W   (BANK_W)
) chk_i (.*);

// File: tb/bank_arb_top_tb_top.sv
// Sweeps bank pairs, priority modes and store/load mixes against a
// bench-side memory model. Defaults: 8-bit address, bank field at bit 2.
module bank_arb_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prio_rotate = 1'b0;
    logic          p0_req = 1'b0, p0_we = 1'b0, p1_req = 1'b0, p1_we = 1'b0;
    logic [AW-1:0] p0_addr = '0, p1_addr = '0;
    logic [DW-1:0] p0_wdata = '0, p1_wdata = '0;
    logic          p0_grant, p0_replay, p0_rvalid, p1_grant, p1_replay, p1_rvalid;
    logic [DW-1:0] p0_rdata, p1_rdata;

    int            tests = 0;
    int            fails = 0;
    logic [DW-1:0] model [256];
    logic          tb_turn = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_arb_top dut_i (.*);

    function automatic logic [DW-1:0] dval(input logic [AW-1:0] a);
        return {a, ~a, a ^ 8'h3C, 8'hC3};
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive both ports, check grant/replay, then the returned data.
    task automatic step(input logic r0, input logic w0, input logic [AW-1:0] a0,
                        input logic [DW-1:0] d0, input logic r1, input logic w1,
                        input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                        input string tag);
        logic conf, w1win, eg0, eg1;
        logic [DW-1:0] ed0, ed1;
        @(negedge clk);
        p0_req = r0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
        p1_req = r1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
        #2;
        conf  = r0 && r1 && (a0[4:2] == a1[4:2]);
        w1win = prio_rotate && tb_turn;
        eg0   = r0 && !(conf && w1win);
        eg1   = r1 && !(conf && !w1win);
        chk(p0_grant == eg0 && p0_replay == (r0 && !eg0), {tag, " p0 grant/replay"},
            {30'd0, p0_grant, p0_replay}, {30'd0, eg0, r0 && !eg0});
        chk(p1_grant == eg1 && p1_replay == (r1 && !eg1), {tag, " p1 grant/replay"},
            {30'd0, p1_grant, p1_replay}, {30'd0, eg1, r1 && !eg1});
        ed0 = model[a0];
        ed1 = model[a1];
        if (!prio_rotate) tb_turn = 1'b0;
        else if (conf) tb_turn = !tb_turn;
        if (eg0 && w0) model[a0] = d0;
        if (eg1 && w1) model[a1] = d1;
        @(posedge clk);
        #1;
        chk(p0_rvalid == (eg0 && !w0), {tag, " R6 p0 rvalid"},
            {31'd0, p0_rvalid}, {31'd0, eg0 && !w0});
        chk(p1_rvalid == (eg1 && !w1), {tag, " R6 p1 rvalid"},
            {31'd0, p1_rvalid}, {31'd0, eg1 && !w1});
        if (eg0 && !w0) chk(p0_rdata == ed0, {tag, " R6 p0 rdata"}, p0_rdata, ed0);
        if (eg1 && !w1) chk(p1_rdata == ed1, {tag, " R6 p1 rdata"}, p1_rdata, ed1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state.
        chk(!p0_rvalid && !p1_rvalid, "R9 rvalid in reset",
            {30'd0, p0_rvalid, p1_rvalid}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 / R2: fill every word, the two ports always in different banks.
        for (int a = 0; a < 256; a++) begin
            if (a[2] == 1'b0) begin
                step(1'b1, 1'b1, AW'(a), dval(AW'(a)),
                     1'b1, 1'b1, AW'(a ^ 4), dval(AW'(a ^ 4)), "R7 R2 fill");
            end
        end

        // R1 R2 R3 R4: loads over all 64 bank pairs, fixed priority.
        for (int b0 = 0; b0 < 8; b0++) begin
            for (int b1 = 0; b1 < 8; b1++) begin
                step(1'b1, 1'b0, {3'(b1), 3'(b0), 2'(b0)}, '0,
                     1'b1, 1'b0, {3'(b0 + 1), 3'(b1), 2'(b1 + 1)}, '0,
                     "R1 R2 R3 R4 pair sweep");
            end
        end

        // R3: both ports load the identical word.
        step(1'b1, 1'b0, 8'h5A, '0, 1'b1, 1'b0, 8'h5A, '0, "R3 same word");

        // R5: rotating priority, with a non-conflict cycle in between.
        prio_rotate = 1'b1;
        step(1'b1, 1'b0, 8'h04, '0, 1'b1, 1'b0, 8'h24, '0, "R5 rot first");
        step(1'b1, 1'b0, 8'h04, '0, 1'b1, 1'b0, 8'h24, '0, "R5 rot second");
        step(1'b1, 1'b0, 8'h08, '0, 1'b1, 1'b0, 8'h0C, '0, "R5 no clash");
        step(1'b1, 1'b0, 8'h10, '0, 1'b1, 1'b0, 8'h30, '0, "R5 rot third");
        step(1'b1, 1'b0, 8'h10, '0, 1'b1, 1'b0, 8'h30, '0, "R5 rot fourth");
        step(1'b1, 1'b0, 8'h10, '0, 1'b1, 1'b0, 8'h30, '0, "R5 rot fifth");
        prio_rotate = 1'b0;
        step(1'b1, 1'b0, 8'h14, '0, 1'b1, 1'b0, 8'h34, '0, "R4 rotation off");
        prio_rotate = 1'b1;
        step(1'b1, 1'b0, 8'h14, '0, 1'b1, 1'b0, 8'h34, '0, "R5 re-enabled");
        prio_rotate = 1'b0;

        // R7: replayed store leaves memory untouched; read it back.
        step(1'b1, 1'b0, 8'h10, '0, 1'b1, 1'b1, 8'h90, 32'hDEAD_BEEF, "R7 replayed store");
        step(1'b1, 1'b0, 8'h90, '0, 1'b0, 1'b0, '0, '0, "R7 readback after replay");

        // R2 R7: store and load in different banks at once, then readback.
        step(1'b1, 1'b1, 8'h44, 32'h1234_5678, 1'b1, 1'b0, 8'h48, '0, "R2 store with load");
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 8'h44, '0, "R7 readback on p1");

        // R8: idle ports.
        step(1'b0, 1'b0, 8'h44, '0, 1'b0, 1'b0, 8'h44, '0, "R8 idle");
        step(1'b0, 1'b1, 8'h44, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'h44, '0, "R8 p0 idle with we");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule